// File: doc/BRIEF.md
# Toggle-Handshake Single-Port RAM

This block is a synchronous single-port memory of 32-bit words. The scheduled controller that uses it has no strobe and no ready line. Instead, the controller starts a request by making its request toggle, a 32-bit word, differ from the memory's 32-bit acknowledge register. At the next clock edge the memory performs exactly one access. That access is a write when write-enable is set and a read otherwise. In the same edge the memory copies the toggle value into the acknowledge register, and this copy closes the request.

Only one request can be in flight at a time. The controller changes its toggle again only after the acknowledge register has caught up with it. Every state change happens at a clock edge, and the memory acts on the values present at its inputs in the cycle before that edge. The depth is a parameter. An address outside the implemented depth still gets a handshake, but it never touches storage.

Top module: `tgl_ram`

## Requirements
- R1: When the acknowledge register equals the request toggle, compared over all 32 bits, nothing changes at the next edge: not the array, not `rd_data`, not `ack_tgl`. A difference in any single bit, including bit 31 alone, counts as a pending request.
- R2: When a request is pending and `wr_en` is 1, the word at `addr` takes the value of `wr_data` at the next edge.
- R3: When a request is pending and `wr_en` is 0, `rd_data` shows the word stored at `addr` after the next edge.
- R4: Serving any pending request, whether a read, a write or an out-of-range access, loads `ack_tgl` with the value `req_tgl` had before that edge.
- R5: A write leaves `rd_data` unchanged, and a read leaves the array contents unchanged.
- R6: An address equal to or greater than DEPTH (default 48) is handled as follows. A write to it changes nothing in storage. A read from it drives `rd_data` to zero. In both cases the request is still acknowledged.
- R7: While `rst` is high at a clock edge, `ack_tgl` and `rd_data` both become zero. A controller that holds `req_tgl` at zero therefore leaves reset with no request pending.
- R8: A request is served at the first edge at which it is pending. A new toggle value presented in the cycle right after an acknowledge is served at the edge that follows, so the memory sustains one access per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes at its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W (8) | Word address of the request |
| wr_en | input | 1 | 1 selects a write, 0 selects a read |
| wr_data | input | 32 | Word to store on a write |
| req_tgl | input | 32 | Request toggle; a pending request exists while it differs from `ack_tgl` |
| rd_data | output | 32 | Registered read result |
| ack_tgl | output | 32 | Acknowledge register; takes the toggle value when a request is served |

## Verification
The embedded properties check, on every cycle, the rules that relate neighbouring cycles:
- an idle cycle holds both `ack_tgl` and `rd_data`;
- a served request copies the previous toggle into `ack_tgl`;
- a write never moves `rd_data`;
- an out-of-range read returns zero.

Whether data actually reaches storage can only be shown by the bench's scenarios. These scenarios cover the following:
- a write read back later, possibly after other accesses;
- an idle cycle whose stray write data must not land in storage;
- an out-of-range write that must not land anywhere;
- a read that must not disturb what a later read returns.

// File: rtl/tgl_ram_pkg.sv
package tgl_ram_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } op_e;

    typedef struct packed {
        op_e  op;
        logic hit;   // address lies inside the implemented depth
    } cmd_t;

    // A request is pending whenever the two words differ in any bit.
    function automatic op_e pick_op(input logic [WORD_W-1:0] ack,
                                    input logic [WORD_W-1:0] req,
                                    input logic              we);
        if (ack == req) return OP_IDLE;
        return we ? OP_WRITE : OP_READ;
    endfunction

endpackage

// File: rtl/tgl_ram_ctrl.sv
module tgl_ram_ctrl
    import tgl_ram_pkg::*;
#(
    parameter int DEPTH  = 48,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] req_tgl,
    output cmd_t              cmd,
    output logic [WORD_W-1:0] ack_q
);
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(DEPTH);

    always_comb begin
        cmd.op  = pick_op(ack_q, req_tgl, wr_en);
        cmd.hit = ({1'b0, addr} < LIMIT);
    end

    always_ff @(posedge clk) begin
        if (rst)
            ack_q <= '0;
        else if (cmd.op != OP_IDLE)
            ack_q <= req_tgl;
    end

    // R1: an idle cycle leaves the acknowledge register alone
    assert_idle_ack_R1: assert property (@(posedge clk) disable iff (rst)
        (req_tgl == ack_q) |=> $stable(ack_q));

    // R4: serving a request copies the earlier toggle value
    assert_ack_copy_R4: assert property (@(posedge clk) disable iff (rst)
        (req_tgl != ack_q) |=> (ack_q == $past(req_tgl)));

endmodule

// File: rtl/tgl_ram_array.sv
module tgl_ram_array
    import tgl_ram_pkg::*;
#(
    parameter int DEPTH = 48,
    parameter int IDX_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_t              cmd,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] mem [0:DEPTH-1];

    always_ff @(posedge clk) begin
        if (cmd.op == OP_WRITE && cmd.hit)
            mem[idx] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else if (cmd.op == OP_READ)
            rd_data <= cmd.hit ? mem[idx] : '0;
    end

    // R5: a write never disturbs the read register
    assert_write_keeps_dout_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == OP_WRITE) |=> $stable(rd_data));

    // R6: out-of-range read yields zero
    assert_oor_read_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd.op == OP_READ && !cmd.hit) |=> (rd_data == '0));

endmodule

// File: rtl/tgl_ram.sv
module tgl_ram
    import tgl_ram_pkg::*;
#(
    parameter int DEPTH  = 48,
    parameter int ADDR_W = 8   // must be at least $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic [31:0]       req_tgl,
    output logic [31:0]       rd_data,
    output logic [31:0]       ack_tgl
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    cmd_t cmd;

    tgl_ram_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wr_en   (wr_en),
        .req_tgl (req_tgl),
        .cmd     (cmd),
        .ack_q   (ack_tgl)
    );

    tgl_ram_array #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_array (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .idx     (addr[IDX_W-1:0]),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );

    // R1: idle cycle leaves the read register alone
    assert_idle_dout_R1: assert property (@(posedge clk) disable iff (rst)
        (req_tgl == ack_tgl) |=> $stable(rd_data));

endmodule

// File: tb/test_tgl_ram.sv
module test_tgl_ram;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  addr;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] req_tgl;
    logic [31:0] rd_data;
    logic [31:0] ack_tgl;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;   // 100 MHz

    tgl_ram #(.DEPTH(48), .ADDR_W(8)) i_tgl_ram (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .req_tgl (req_tgl),
        .rd_data (rd_data),
        .ack_tgl (ack_tgl)
    );

    typedef struct packed {
        logic [31:0] req;
        logic        we;
        logic [7:0]  a;
        logic [31:0] d;
        logic [31:0] exp_dout;
        logic [31:0] exp_ack;
        logic [3:0]  rq;     // requirement number mainly exercised
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{32'd1,  1'b1, 8'd3,   32'hA5A5_0001, 32'h0,          32'd1,  4'd2}, // R2 write, R5 dout holds
        '{32'd2,  1'b1, 8'd10,  32'h1234_5678, 32'h0,          32'd2,  4'd8}, // R8 back-to-back
        '{32'd3,  1'b0, 8'd3,   32'h0,         32'hA5A5_0001,  32'd3,  4'd3}, // R3 read
        '{32'd3,  1'b1, 8'd3,   32'hFFFF_FFFF, 32'hA5A5_0001,  32'd3,  4'd1}, // R1 idle, stray write
        '{32'd4,  1'b0, 8'd3,   32'h0,         32'hA5A5_0001,  32'd4,  4'd1}, // R1 array untouched
        '{32'h8000_0004, 1'b1, 8'd47, 32'h0000_CAFE, 32'hA5A5_0001, 32'h8000_0004, 4'd1}, // R1 bit 31
        '{32'h8000_0004, 1'b0, 8'd47, 32'h0,   32'hA5A5_0001,  32'h8000_0004, 4'd1}, // R1 idle read
        '{32'd5,  1'b0, 8'd10,  32'h0,         32'h1234_5678,  32'd5,  4'd3}, // R3
        '{32'd6,  1'b1, 8'd200, 32'hDEAD_BEEF, 32'h1234_5678,  32'd6,  4'd6}, // R6 oor write acked
        '{32'd7,  1'b0, 8'd200, 32'h0,         32'h0,          32'd7,  4'd6}, // R6 oor read zero
        '{32'd8,  1'b0, 8'd47,  32'h0,         32'h0000_CAFE,  32'd8,  4'd3}, // R3 last location
        '{32'd9,  1'b1, 8'd48,  32'hBAD0_0048, 32'h0000_CAFE,  32'd9,  4'd6}, // R6 first oor addr
        '{32'd10, 1'b0, 8'd10,  32'h0,         32'h1234_5678,  32'd10, 4'd5}, // R5 read kept array
        '{32'd11, 1'b0, 8'd3,   32'h0,         32'hA5A5_0001,  32'd11, 4'd5}  // R5
    };

    task automatic check(input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] r, input logic w,
                         input logic [7:0] a, input logic [31:0] d);
        req_tgl = r; wr_en = w; addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; req_tgl = '0; wr_en = 1'b0; addr = '0; wr_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R7", "ack after reset", ack_tgl, 32'h0);
        check("R7", "dout after reset", rd_data, 32'h0);
        rst = 1'b0;

        // R1: equal words after reset, stray write must not land
        drive(32'h0, 1'b1, 8'd3, 32'h7777_7777);
        check("R1", "ack idle", ack_tgl, 32'h0);
        check("R1", "dout idle", rd_data, 32'h0);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].req, VECS[i].we, VECS[i].a, VECS[i].d);
            check($sformatf("R%0d", VECS[i].rq), $sformatf("vec %0d dout", i),
                  rd_data, VECS[i].exp_dout);
            check("R4", $sformatf("vec %0d ack", i), ack_tgl, VECS[i].exp_ack);
        end

        // R8: a held toggle is served once; further cycles stay idle
        drive(32'd12, 1'b0, 8'd47, 32'h0);
        check("R8", "served at first edge", rd_data, 32'h0000_CAFE);
        drive(32'd12, 1'b1, 8'd47, 32'h5555_5555);
        drive(32'd13, 1'b0, 8'd47, 32'h0);
        check("R8", "held toggle did not write", rd_data, 32'h0000_CAFE);

        // R7: reset in mid-run clears both registers
        req_tgl = 32'd0; rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R7", "ack after mid reset", ack_tgl, 32'h0);
        check("R7", "dout after mid reset", rd_data, 32'h0);
        rst = 1'b0;
        drive(32'h0, 1'b0, 8'd3, 32'h0);
        check("R7", "no request pending after reset", rd_data, 32'h0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule